// File: doc/BRIEF.md
# Speed-Scaled Cycle Timer Controller

This block governs bus timing and timer prescaling for a small 8-bit audio coprocessor. A single control byte, written over the processor bus, holds two 2-bit speed codes: one for the internal clock, and one for external RAM accesses. It also holds four single-bit flags for the timers and the RAM. On each accepted bus cycle the block works out which speed code applies. The choice depends on the address, on whether the cycle is idle, and on whether the boot ROM is mapped in. That speed sets two things: how many base-clock wait states the bus must stall after the cycle, and how far each timer's prescaler advances.

There are three timers. Each has a stage-0 accumulator that divides the per-cycle step down to stage-1 ticks. Each stage-1 tick feeds an 8-bit counter that is compared against a target. Each time the counter reaches its target, a 4-bit output counter steps. One clock of the block equals one base clock of the processor, so a stall of N cycles is an N-base-clock wait.

Top module: `spd_cycle_timer`

## Requirements
- R1: After reset, `ctrlValue` reads 0x0A, and `stall`, `tickPulse` and `timerOut` are all zero. The 0x0A value means both speed codes are 0, timers are enabled, RAM is not disabled and RAM is writable.
- R2: The control byte is loaded from `accWdata` at the accepting edge of a non-idle write to address 0x00F0 while `pFlag` is 0. Its fields are:
  - bits 7:6: clock speed
  - bits 5:4: RAM speed
  - bit 3: timers enabled
  - bit 2: RAM disabled
  - bit 1: RAM writable
  - bit 0: timers halted
- R3: A write to 0x00F0 while `pFlag` is 1 leaves `ctrlValue` unchanged.
- R4: `accSpeed` equals the clock-speed field in three cases: for idle cycles, for addresses 0x00F0 to 0x00FF, and for addresses 0xFFC0 and above while `bootRomEn` is 1. For every other address it equals the RAM-speed field.
- R5: An access is accepted on a rising edge where `accValid` is 1 and `stall` is 0. After an access at speed s, `stall` is high for exactly 24*s*s cycles (0, 24, 96 or 216). An `accValid` raised while `stall` is high has no effect.
- R6: Each accepted access adds 1<<s to every timer's stage-0 accumulator. Timers 0 and 1 divide by 64 and timer 2 divides by 8. When the sum reaches the divider, the divider is subtracted, and `tickPulse[i]` is high for the one cycle after the accepting edge.
- R7: Each stage-1 tick increments timer i's 8-bit counter. When the incremented value equals target byte i (`timerTarget[8i+7:8i]`, where 0 means 256), the counter clears and nibble i of `timerOut` increments, wrapping modulo 16.
- R8: Stage-1 counting happens only while bit 3 is 1 and bit 0 is 0 of the control byte. Otherwise ticks still pulse but `timerOut` does not change. Every use of the control byte within an access, including its speed codes, takes the value held before that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access request |
| accIdle | input | 1 | Request is an idle (no memory) cycle |
| accWrite | input | 1 | Request is a write |
| accAddr | input | 16 | Access address |
| accWdata | input | 8 | Write data |
| pFlag | input | 1 | Processor P flag; blocks control writes when 1 |
| bootRomEn | input | 1 | Boot ROM mapped at the top of memory |
| timerTarget | input | 24 | Stage-1 target bytes, timer i at bits 8i+7:8i |
| stall | output | 1 | Wait states pending; no access accepted |
| accSpeed | output | 2 | Speed code selected for the current request |
| ctrlValue | output | 8 | Current control byte |
| tickPulse | output | 3 | One-cycle stage-1 tick per timer |
| timerOut | output | 12 | 4-bit output counters, timer i at bits 4i+3:4i |

## Verification
The bound assertions check, on every cycle, the rules that link consecutive clocks:
- the control byte and the timer outputs stay frozen between accepted accesses;
- a P-flag-blocked write changes nothing;
- ticks appear only after an accepted access;
- a speed-0 access never stalls while a faster-coded one always does;
- idle cycles always select the clock-speed field;
- the fast timer ticks on every speed-3 access.

Only the bench scenarios can show the exact stall lengths and the address-window speed selection with the boot ROM on and off. They also show the prescaler remainders carried across accesses, the target matching (including target 0 as 256), the halting of stage-1 counting, and that a request raised during a stall is dropped.

// File: rtl/spd_pkg.sv
package spd_pkg;
  parameter int SPD_W = 2;
  parameter int NUM_TMR = 3;

  typedef struct packed {
    logic             accept;
    logic [SPD_W-1:0] speed;
    logic             runStage1;
  } ctlStrobes_t;
endpackage

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
#(
  parameter int          CYCLE_CLKS = 24,
  parameter logic [15:0] CTRL_ADDR  = 16'h00F0,
  parameter logic [15:0] ROM_BASE   = 16'hFFC0,
  parameter logic [7:0]  RESET_CTRL = 8'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accIdle,
  input  logic              accWrite,
  input  logic [15:0]       accAddr,
  input  logic [7:0]        accWdata,
  input  logic              pFlag,
  input  logic              bootRomEn,
  output logic              stall,
  output logic [SPD_W-1:0]  accSpeed,
  output logic [7:0]        ctrlValue,
  output ctlStrobes_t       strobes
);
  localparam int MAX_SPD = (1 << SPD_W) - 1;
  localparam int WAIT_W  = $clog2(CYCLE_CLKS * MAX_SPD * MAX_SPD + 1);

  logic [7:0]        ctrlReg;
  logic [WAIT_W-1:0] waitLeft;
  logic [WAIT_W-1:0] waitFor;
  logic              ioPage, romArea, useClk, accept, ctrlWrite;

  always_comb begin
    ioPage    = (accAddr[15:4] == CTRL_ADDR[15:4]);
    romArea   = bootRomEn && (accAddr >= ROM_BASE);
    useClk    = accIdle || ioPage || romArea;
    accSpeed  = useClk ? ctrlReg[7:6] : ctrlReg[5:4];
    accept    = accValid && (waitLeft == '0);
    ctrlWrite = accept && accWrite && !accIdle && !pFlag && (accAddr == CTRL_ADDR);
    waitFor   = WAIT_W'(accSpeed) * WAIT_W'(accSpeed) * WAIT_W'(CYCLE_CLKS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= RESET_CTRL;
      waitLeft <= '0;
    end else begin
      if (ctrlWrite) ctrlReg <= accWdata;
      if (accept) waitLeft <= waitFor;
      else if (waitLeft != '0) waitLeft <= waitLeft - 1'b1;
    end
  end

  assign stall             = (waitLeft != '0);
  assign ctrlValue         = ctrlReg;
  assign strobes.accept    = accept;
  assign strobes.speed     = accSpeed;
  assign strobes.runStage1 = ctrlReg[3] & ~ctrlReg[0];
endmodule

// File: rtl/spd_timers.sv
module spd_timers
  import spd_pkg::*;
#(
  parameter int DIV_SLOW = 64,
  parameter int DIV_FAST = 8,
  parameter int CNT_W    = 8,
  parameter int OUT_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              strobes,
  input  logic [NUM_TMR*CNT_W-1:0] timerTarget,
  output logic [NUM_TMR-1:0]       tickPulse,
  output logic [NUM_TMR*OUT_W-1:0] timerOut
);
  localparam int MAX_STEP = 1 << ((1 << SPD_W) - 1);
  localparam int ACC_W    = $clog2(DIV_SLOW + MAX_STEP + 1);

  logic [ACC_W-1:0] step;
  assign step = ACC_W'(1) << strobes.speed;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int DIV = (i == NUM_TMR - 1) ? DIV_FAST : DIV_SLOW;
    logic [ACC_W-1:0] acc, sum, accNext;
    logic [CNT_W-1:0] cnt, cntInc, tgt;
    logic [OUT_W-1:0] outCnt;
    logic             hit, tickR;

    always_comb begin
      sum     = acc + step;
      hit     = (sum >= ACC_W'(DIV));
      accNext = hit ? sum - ACC_W'(DIV) : sum;
      tgt     = timerTarget[i*CNT_W +: CNT_W];
      cntInc  = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc    <= '0;
        cnt    <= '0;
        outCnt <= '0;
        tickR  <= 1'b0;
      end else if (strobes.accept) begin
        acc   <= accNext;
        tickR <= hit;
        if (hit && strobes.runStage1) begin
          if (cntInc == tgt) begin
            cnt    <= '0;
            outCnt <= outCnt + 1'b1;
          end else begin
            cnt <= cntInc;
          end
        end
      end else begin
        tickR <= 1'b0;
      end
    end

    assign tickPulse[i]                 = tickR;
    assign timerOut[i*OUT_W +: OUT_W]   = outCnt;
  end
endmodule

// File: rtl/spd_cycle_timer.sv
module spd_cycle_timer
  import spd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        accIdle,
  input  logic        accWrite,
  input  logic [15:0] accAddr,
  input  logic [7:0]  accWdata,
  input  logic        pFlag,
  input  logic        bootRomEn,
  input  logic [23:0] timerTarget,
  output logic        stall,
  output logic [1:0]  accSpeed,
  output logic [7:0]  ctrlValue,
  output logic [2:0]  tickPulse,
  output logic [11:0] timerOut
);
  ctlStrobes_t strobes;

  spd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIdle(accIdle),
    .accWrite(accWrite), .accAddr(accAddr), .accWdata(accWdata),
    .pFlag(pFlag), .bootRomEn(bootRomEn), .stall(stall),
    .accSpeed(accSpeed), .ctrlValue(ctrlValue), .strobes(strobes)
  );

  spd_timers u_timers (
    .clk(clk), .rstN(rstN), .strobes(strobes), .timerTarget(timerTarget),
    .tickPulse(tickPulse), .timerOut(timerOut)
  );
endmodule

// File: rtl/spd_cycle_timer_chk.sv
module spd_cycle_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic        accIdle,
  input logic        accWrite,
  input logic [15:0] accAddr,
  input logic [7:0]  accWdata,
  input logic        pFlag,
  input logic        bootRomEn,
  input logic [23:0] timerTarget,
  input logic        stall,
  input logic [1:0]  accSpeed,
  input logic [7:0]  ctrlValue,
  input logic [2:0]  tickPulse,
  input logic [11:0] timerOut
);
  logic accepted;
  assign accepted = accValid && !stall;

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> $stable(ctrlValue));

  p_pflag_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && accWrite && !accIdle && pFlag && accAddr == 16'h00F0) |=> $stable(ctrlValue));

  p_idle_clock_r4: assert property (@(posedge clk) disable iff (!rstN)
    accIdle |-> (accSpeed == ctrlValue[7:6]));

  p_no_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && accSpeed == 2'd0) |=> !stall);

  p_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && accSpeed != 2'd0) |=> stall);

  p_tick_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> (tickPulse == 3'b000));

  p_fast_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && accSpeed == 2'd3) |=> tickPulse[2]);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> $stable(timerOut));
endmodule

bind spd_cycle_timer spd_cycle_timer_chk u_chk (.*);

// File: tb/spd_cycle_timer_tb.sv
module spd_cycle_timer_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid, accIdle, accWrite, pFlag, bootRomEn;
  logic [15:0] accAddr;
  logic [7:0]  accWdata;
  logic [23:0] timerTarget;
  logic        stall;
  logic [1:0]  accSpeed;
  logic [7:0]  ctrlValue;
  logic [2:0]  tickPulse;
  logic [11:0] timerOut;

  always #2 clk = ~clk;

  spd_cycle_timer u_dut (.*);

  typedef struct {
    logic [7:0]  ctrl;
    logic [2:0]  tick;
    logic [11:0] outs;
    int          waitCycles;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int  checks = 0, fails = 0;
  bit  busy = 0, finished = 0;

  logic [7:0] mCtrl;
  int         mAcc[3], mCnt[3], mOut[3];
  int         mTgt[3];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] refSpeed(logic [15:0] a, bit idle, bit boot);
    if (idle || a[15:4] == 12'h00F || (boot && a >= 16'hFFC0)) return mCtrl[7:6];
    return mCtrl[5:4];
  endfunction

  task automatic doAcc(logic [15:0] a, bit idle, bit wr, logic [7:0] d,
                       bit pf, bit boot, bit intrude, string tag);
    expItem_t it;
    logic [1:0] s;
    int stepV, div;
    bit run;
    wait (!busy);
    @(negedge clk);
    accValid = 1; accAddr = a; accIdle = idle; accWrite = wr;
    accWdata = d; pFlag = pf; bootRomEn = boot;
    s = refSpeed(a, idle, boot);
    #1;
    check(accSpeed == s, "R4", "accSpeed", accSpeed, s);
    stepV = 1 << s;
    run = mCtrl[3] && !mCtrl[0];
    it.tick = '0;
    for (int i = 0; i < 3; i++) begin
      div = (i == 2) ? 8 : 64;
      mAcc[i] += stepV;
      if (mAcc[i] >= div) begin
        mAcc[i] -= div;
        it.tick[i] = 1'b1;
        if (run) begin
          mCnt[i] = (mCnt[i] + 1) % 256;
          if (mCnt[i] == mTgt[i]) begin
            mCnt[i] = 0;
            mOut[i] = (mOut[i] + 1) % 16;
          end
        end
      end
    end
    if (wr && !idle && !pf && a == 16'h00F0) mCtrl = d;
    it.ctrl = mCtrl;
    it.outs = {4'(mOut[2]), 4'(mOut[1]), 4'(mOut[0])};
    it.waitCycles = 24 * int'(s) * int'(s);
    it.tag = tag;
    busy = 1;
    scoreQ.push_back(it);
    @(negedge clk);
    accValid = 0;
    if (intrude) begin
      accValid = 1; accAddr = 16'h00F0; accWrite = 1; accIdle = 0;
      accWdata = 8'h55; pFlag = 0;
      @(negedge clk);
      accValid = 0;
    end
    wait (!busy);
  endtask

  initial begin : monitor
    expItem_t e;
    int n;
    forever begin
      wait (scoreQ.size() > 0);
      @(posedge clk);
      @(negedge clk);
      e = scoreQ.pop_front();
      check(ctrlValue == e.ctrl, e.tag, "ctrlValue", ctrlValue, e.ctrl);
      check(tickPulse == e.tick, "R6", "tickPulse", tickPulse, e.tick);
      check(timerOut == e.outs, "R7", "timerOut", timerOut, e.outs);
      n = 0;
      while (stall) begin
        n++;
        @(negedge clk);
      end
      check(n == e.waitCycles, "R5", "stall cycles", n, e.waitCycles);
      busy = 0;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin : driver
    rstN = 0; accValid = 0; accIdle = 0; accWrite = 0; pFlag = 0;
    bootRomEn = 0; accAddr = '0; accWdata = '0;
    timerTarget = {8'h00, 8'h03, 8'h02};
    mTgt[0] = 2; mTgt[1] = 3; mTgt[2] = 0;
    for (int i = 0; i < 3; i++) begin mAcc[i] = 0; mCnt[i] = 0; mOut[i] = 0; end
    mCtrl = 8'h0A;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(ctrlValue == 8'h0A, "R1", "ctrlValue", ctrlValue, 8'h0A);
    check(stall == 1'b0, "R1", "stall", stall, 0);
    check(tickPulse == 3'b0, "R1", "tickPulse", tickPulse, 0);
    check(timerOut == 12'h0, "R1", "timerOut", timerOut, 0);
    rstN = 1;

    doAcc(16'h0000, 1, 0, 8'h00, 0, 0, 0, "R4");
    doAcc(16'h00F0, 0, 1, 8'hC0, 1, 0, 0, "R3");
    doAcc(16'h00F0, 0, 1, 8'h1A, 0, 0, 0, "R2");
    doAcc(16'h1234, 0, 0, 8'h00, 0, 0, 0, "R5");
    doAcc(16'h00F5, 0, 0, 8'h00, 0, 0, 0, "R4");
    doAcc(16'hFFC5, 0, 0, 8'h00, 0, 1, 0, "R4");
    doAcc(16'hFFC5, 0, 0, 8'h00, 0, 0, 0, "R4");
    doAcc(16'h00F0, 0, 1, 8'h8A, 0, 0, 0, "R2");
    doAcc(16'h0000, 1, 0, 8'h00, 0, 0, 0, "R5");
    doAcc(16'h0200, 0, 0, 8'h00, 0, 0, 0, "R4");
    for (int k = 0; k < 40; k++) doAcc(16'h0200, 0, 0, 8'h00, 0, 0, 0, "R6");
    // R8: timers halted by bit 0
    doAcc(16'h00F0, 0, 1, 8'h0B, 0, 0, 0, "R8");
    for (int k = 0; k < 70; k++) doAcc(16'h0300, 0, 0, 8'h00, 0, 0, 0, "R8");
    // R8: timers disabled by bit 3
    doAcc(16'h00F0, 0, 1, 8'h02, 0, 0, 0, "R8");
    for (int k = 0; k < 20; k++) doAcc(16'h0300, 0, 0, 8'h00, 0, 0, 0, "R8");
    doAcc(16'h00F0, 0, 1, 8'h3A, 0, 0, 0, "R2");
    // R5: request during stall must be dropped
    doAcc(16'h0400, 0, 0, 8'h00, 0, 0, 1, "R5");
    doAcc(16'h0401, 0, 0, 8'h00, 0, 0, 0, "R5");
    // R7: long run at speed 3, including target 0 meaning 256
    for (int k = 0; k < 260; k++) doAcc(16'h0400, 0, 0, 8'h00, 0, 0, 0, "R7");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule